// File: doc/BRIEF.md
# Serial ROM Target Interface

This block is the device end of a read-only memory reached over an SPI-style serial bus. A host pulls chip select low, shifts in a one-byte opcode, and, depending on that opcode, either an address, an address plus a throw-away byte, or nothing at all. The block then streams bytes back on its serial output until chip select goes high again. Three opcodes are recognised: a plain read, a fast read that inserts one dummy byte before data, and an identification read that returns a fixed three-byte signature. Any other opcode parks the block in a silent standby state for the rest of that select.

All four bus pins are sampled by the chip's system clock through a two-stage synchronizer. Edges of the serial clock are detected in the system domain, so the serial clock must run well below the system clock (at least six system clocks per serial half period). The serial output is presented as a data bit plus an output enable; the pad ring forms the tri-state driver from the two. The memory contents are a small computed array; the 23-bit address aliases onto it.

Top module: `spi_rom_target`

## Requirements
- R1: Input bits are taken at serial clock rising edges and output bits change only at serial clock falling edges; both directions carry bytes most significant bit first.
- R2: Opcode 0x03 is followed by three address bytes; the first data bit appears at the falling edge that follows the last address bit, and the first byte is the memory byte at that address.
- R3: Opcode 0x0B is followed by three address bytes and one dummy byte whose value is ignored; data starts at the falling edge after the last dummy bit.
- R4: Opcode 0x9F takes no address and returns 0xAE, then 0x41, then 0x15, starting at the falling edge after the last opcode bit.
- R5: The address is 23 bits: the top bit of the first address byte is discarded and the remaining 23 bits give the address, high bit first.
- R6: Any other opcode places the block in standby: so_oe stays low for every further bit of that select, and the next select decodes a fresh opcode.
- R7: A read returns successive bytes while chip select stays low; the address advances by one per byte and wraps from 0x7FFFFF to 0x000000.
- R8: so_oe is low during opcode, address and dummy bits, after reset, and within a few system clocks of chip select going high.
- R9: After the third identification byte so_oe is low until chip select rises.
- R10: The memory byte at address a is (a[5:0] * 37 + 11) mod 256 with the default 6-bit array index.
- R11: Raising chip select part way through a command abandons it; the next select starts from the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host, idles low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; low means high-Z |

## Verification
The bench aims at the exact bit at which each opcode starts driving: a design that counted one byte too few or too many in the preamble would drive the enable during the last address or dummy bit, or shift the whole data stream by a byte. It reads across the top of the address space to catch a counter that saturates or wraps at the array size instead of the full address, and sends a first address byte with its top bit set to catch a 24-bit address. An unknown opcode followed by more clocks catches a design that resumes decoding mid-select, and a select dropped inside the address phase catches state that survives into the next command.

// File: rtl/spi_rom_pkg.sv
// Shared types and constants for the serial ROM target.
// Assumes: byte-wide memory, three-byte identification sequence.
package spi_rom_pkg;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_IDENT,
        PH_STANDBY,
        PH_DONE
    } phase_t;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_IDENT = 8'h9F;
    localparam int         ID_LEN   = 3;

    // Identification byte at position idx.
    function automatic logic [7:0] ident_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'hAE;
            2'd1:    return 8'h41;
            default: return 8'h15;
        endcase
    endfunction

    // Memory content at array index i (R10).
    function automatic logic [7:0] rom_byte(input int i);
        logic [7:0] x;
        x = 8'(i);
        return 8'(x * 8'd37 + 8'd11);
    endfunction

endpackage

// File: rtl/spi_rom_sync.sv
// Two-stage synchronizer for a vector of asynchronous pins.
// Assumes: each bit is independent; RST_VAL gives the idle level of each pin.
module spi_rom_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Resolve metastability over two flops, idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/spi_rom_array.sv
// Read-only byte array with computed contents and combinational read.
// Assumes: DEPTH is small enough to build as constants.
module spi_rom_array #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign mem[g] = spi_rom_pkg::rom_byte(g);
    end

    assign data = mem[addr];
endmodule

// File: rtl/spi_rom_ctrl.sv
// Command decoder and serial shifter. Works on synchronized pins:
// detects serial clock edges, collects opcode/address on rising edges,
// updates the output bit on falling edges.
// Assumes: the serial clock idles low and each half period spans
// several system clocks.
module spi_rom_ctrl
    import spi_rom_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int ROM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              sclk_s,
    input  logic              si_s,
    input  logic [7:0]        rom_data,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              so_q,
    output logic              so_en
);
    phase_t            phase_q;
    logic [2:0]        bit_q;
    logic [1:0]        nbyte_q;
    logic [1:0]        id_q;
    logic              fast_q;
    logic [6:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sclk_d;
    logic              rise;
    logic              fall;
    logic [7:0]        opcode;
    logic [7:0]        cur_byte;

    // Remember previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign opcode   = {op_q, si_s};
    assign rom_addr = addr_q[ROM_AW-1:0];
    assign cur_byte = (phase_q == PH_IDENT) ? ident_byte(id_q) : rom_data;

    // Command phase sequencing on rising serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_hi) begin
            phase_q <= PH_OPCODE;
            bit_q   <= '0;
            nbyte_q <= '0;
            id_q    <= '0;
            fast_q  <= 1'b0;
            op_q    <= '0;
            addr_q  <= '0;
        end else if (rise) begin
            bit_q <= bit_q + 3'd1;
            case (phase_q)
                PH_OPCODE: begin
                    op_q <= opcode[6:0];
                    if (bit_q == 3'd7) begin
                        case (opcode)
                            OP_READ:  begin phase_q <= PH_ADDR;  fast_q <= 1'b0; end
                            OP_FAST:  begin phase_q <= PH_ADDR;  fast_q <= 1'b1; end
                            OP_IDENT: phase_q <= PH_IDENT;
                            default:  phase_q <= PH_STANDBY;
                        endcase
                    end
                end
                PH_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-2:0], si_s};
                    if (bit_q == 3'd7) begin
                        if (nbyte_q == 2'd2) begin
                            nbyte_q <= '0;
                            phase_q <= fast_q ? PH_DUMMY : PH_DATA;
                        end else begin
                            nbyte_q <= nbyte_q + 2'd1;
                        end
                    end
                end
                PH_DUMMY: begin
                    if (bit_q == 3'd7) phase_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (bit_q == 3'd7) addr_q <= addr_q + ADDR_W'(1);
                end
                PH_IDENT: begin
                    if (bit_q == 3'd7) begin
                        if (id_q == 2'(ID_LEN - 1)) phase_q <= PH_DONE;
                        else                        id_q    <= id_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output bit and enable update on falling serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_q  <= 1'b0;
            so_en <= 1'b0;
        end else if (cs_hi) begin
            so_en <= 1'b0;
        end else if (fall) begin
            so_en <= (phase_q == PH_DATA) || (phase_q == PH_IDENT);
            so_q  <= cur_byte[~bit_q];
        end
    end

    AST_BIT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(so_q)); // R1
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !so_en); // R8
    AST_EN_IN_OUTPUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> (phase_q inside {PH_DATA, PH_IDENT, PH_DONE})); // R8
    AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STANDBY) |-> !so_en); // R6
    AST_ID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDENT) |-> (id_q < 2'(ID_LEN))); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !cs_hi && phase_q == PH_DATA && bit_q == 3'd7)
        |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R7
endmodule

// File: rtl/spi_rom_target.sv
// Top of the serial ROM target: synchronizes the bus pins, decodes
// commands and serves bytes from the computed array.
// Assumes: serial clock at most clk/12; pad ring builds the tri-state
// driver from so and so_oe.
module spi_rom_target #(
    parameter int ADDR_W = 23,
    parameter int ROM_AW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic so,
    output logic so_oe
);
    logic [2:0]        pins_s;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0]        rom_data;

    spi_rom_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, si}),
        .q     (pins_s)
    );

    spi_rom_array #(.AW(ROM_AW)) u_array (
        .addr (rom_addr),
        .data (rom_data)
    );

    spi_rom_ctrl #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .si_s     (pins_s[0]),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .so_q     (so),
        .so_en    (so_oe)
    );
endmodule

// File: tb/spi_rom_target_test.sv
module spi_rom_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic si = 1'b0;
    logic so;
    logic so_oe;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit en;
        bit val;
        int req;
    } exp_t;

    exp_t q[$];

    spi_rom_target uut (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // R10: content formula.
    function automatic logic [7:0] rom_model(input logic [22:0] a);
        logic [7:0] i;
        i = {2'b00, a[5:0]};
        return 8'(i * 8'd37 + 8'd11);
    endfunction

    function automatic logic [7:0] id_model(input int i);
        case (i)
            0:       return 8'hAE;
            1:       return 8'h41;
            default: return 8'h15;
        endcase
    endfunction

    // Monitor: one expected item per serial bit, compared at the rising edge.
    always @(posedge sclk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (so_oe !== e.en) begin
                errors++;
                $display("FAIL R%0d: so_oe=%b expected %b", e.req, so_oe, e.en);
            end else if (e.en && so !== e.val) begin
                errors++;
                $display("FAIL R%0d: so=%b expected %b", e.req, so, e.val);
            end
        end
    end

    task automatic check_hiz(input int req);
        @(posedge clk); #1;
        checks++;
        if (so_oe !== 1'b0) begin
            errors++;
            $display("FAIL R%0d: so_oe=%b expected 0", req, so_oe);
        end
    endtask

    // Driver: kind 0 = no output, 1 = memory stream, 2 = identification.
    task automatic xfer(input logic [7:0] op, input logic [23:0] a24,
                        input int nhdr, input int nout, input int kind, input int req);
        cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int k = 0; k < (nhdr + nout) * 8; k++) begin
            exp_t e;
            int j;
            int bi;
            logic [7:0] eb;
            if (k < 8)       si = op[7 - k];
            else if (k < 32) si = a24[31 - k];
            else             si = k[0];
            e.req = req;
            e.val = 1'b0;
            if (k < nhdr * 8) begin
                e.en  = 1'b0;
                e.req = 8; // R8: high-Z in preamble
            end else begin
                j  = k - nhdr * 8;
                bi = j / 8;
                if (kind == 1) begin
                    eb    = rom_model(23'(a24[22:0] + 23'(bi)));
                    e.en  = 1'b1;
                    e.val = eb[7 - (j % 8)];
                end else if (kind == 2 && bi < 3) begin
                    eb    = id_model(bi);
                    e.en  = 1'b1;
                    e.val = eb[7 - (j % 8)];
                end else begin
                    e.en = 1'b0;
                    if (kind == 2) e.req = 9; // R9
                end
            end
            q.push_back(e);
            repeat (HALF) @(posedge clk);
            sclk = 1'b1;
            repeat (HALF) @(posedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(posedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(posedge clk);
        check_hiz(8); // R8: deselected
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        check_hiz(8);                                  // R8 reset state
        xfer(8'h03, 24'h000010, 4, 3, 1, 2);           // R2 plain read, R1 bit order
        xfer(8'h0B, 24'h000021, 5, 2, 1, 3);           // R3 fast read with dummy
        xfer(8'h9F, 24'hFFFFFF, 1, 5, 2, 4);           // R4 identification, R9 after end
        xfer(8'h03, 24'h800005, 4, 2, 1, 5);           // R5 top address bit ignored
        xfer(8'h03, 24'h7FFFFF, 4, 3, 1, 7);           // R7 wrap to zero
        xfer(8'h0B, 24'h00003E, 5, 4, 1, 10);          // R10 array top and alias
        xfer(8'h55, 24'h00AA00, 1, 4, 0, 6);           // R6 unknown opcode standby
        xfer(8'h03, 24'h000002, 4, 1, 1, 6);           // R6 fresh decode next select
        xfer(8'h03, 24'h123456, 2, 0, 0, 11);          // R11 abandon in address phase
        xfer(8'h9F, 24'h000000, 1, 3, 2, 11);          // R11 fresh opcode afterwards
        xfer(8'h03, 24'h000030, 4, 2, 1, 11);          // R11 read after abort
        repeat (HALF) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule